// File: doc/BRIEF.md
# Accumulator and Index Shift Unit

This block performs the shift family of a small 16-bit processor on its accumulator (A), its index register (X) and the one-bit overflow link (OV). A single start strobe loads A, X and OV together with an operation code and a place count. The unit then works one place per clock until the count is used up and pulses done. The updated registers are available on the outputs. They hold their value until the next accepted start.

Three shift kinds are supported: logical, arithmetic and rotate. Each takes a direction and a target: A alone, X alone, or the 32-bit pair with A as the upper half. Every rotate passes through OV, so a single-register rotate is a 17-bit ring and a pair rotate is a 33-bit ring. The unit can also copy the top bit or the bottom bit of A or X into OV. A normalize operation shifts X left until its two top bits differ and reports how many places it moved.

The controller has four states. IDLE waits for start. SHIFT performs one place per clock. NORM performs one normalize step per clock. FINISH raises done for one cycle. The transitions are:
- IDLE to FINISH on start for a copy or a zero count.
- IDLE to NORM on start for normalize.
- IDLE to SHIFT on start for any other operation.
- SHIFT to FINISH when the last place is taken.
- NORM to FINISH when the stop condition holds.
- FINISH to IDLE always.

Top module: `ax_shifter`

## Requirements
- R1: After reset, a_out, x_out, ov_out and norm_places are 0, and busy and done are low.
- R2: A start in IDLE loads a_in, x_in and ov_in. A count of N places raises done N+1 clocks after the start edge; a count of 0 raises done after 1 clock and leaves the registers unchanged.
- R3: kind 0 is the logical shift. It fills the vacated bit with 0, discards the bit shifted out and leaves OV unchanged. left=1 shifts toward the MSB. sel 0 selects A and sel 1 selects X; the register that is not selected is unchanged.
- R4: kind 1 is the arithmetic shift. Right copies the sign bit into the vacated bit and leaves OV unchanged. Left fills with 0 and sets OV if the top two bits differ before any step; a left shift never clears OV.
- R5: kind 2 is the rotate. It turns the 17-bit ring {OV, reg}. On a left rotate the MSB goes to OV and OV goes to the LSB. A right rotate does the reverse.
- R6: sel 2 or 3 makes kinds 0 to 2 act on the 32-bit word {A, X}, with A in the upper half. The rotate ring is {OV, A, X}.
- R7: kind 4 copies one bit into OV, with done one clock after start. left=1 takes the MSB and left=0 takes the LSB. sel[0]=0 takes the bit from A and sel[0]=1 from X. A and X are unchanged.
- R8: kind 3 normalizes X. It shifts X left one place per clock until X is 0 or bit 15 differs from bit 14. norm_places gives the number of places shifted. done comes places+2 clocks after start, and A and OV are unchanged.
- R9: busy is high from the clock after an accepted start through the done cycle. A start while busy is ignored.
- R10: done is high for exactly one clock. While idle without start, the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| kind | input | 3 | Operation kind: 0 logical, 1 arithmetic, 2 rotate, 3 normalize, 4 copy to OV |
| left | input | 1 | Direction (1 = toward MSB) or bit choice for copy (1 = MSB) |
| sel | input | 2 | Target: 0 A, 1 X, 2/3 A:X pair |
| count | input | 5 | Number of places |
| a_in | input | 16 | A value loaded at start |
| x_in | input | 16 | X value loaded at start |
| ov_in | input | 1 | OV value loaded at start |
| a_out | output | 16 | Current A |
| x_out | output | 16 | Current X |
| ov_out | output | 1 | Current OV |
| norm_places | output | 5 | Places moved by the last normalize (0 after other operations) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The time each result is due depends on the operation:
- A shift of N places raises done on the (N+1)th rising edge after the edge that samples start.
- A copy or a zero count raises done on the first edge.
- A normalize that moves k places raises done on edge k+2.

Each stimulus records its expected latency. The bench counts edges from the start edge and samples done on falling edges. It compares the latency and all outputs in the cycle done is first seen. It then checks that done drops and that the outputs stay stable while the unit is idle.

// File: rtl/ax_shift_pkg.sv
package ax_shift_pkg;

    typedef enum logic [2:0] {
        K_LOG  = 3'd0,
        K_ARI  = 3'd1,
        K_ROT  = 3'd2,
        K_NORM = 3'd3,
        K_COPY = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SHIFT  = 2'd1,
        S_NORM   = 2'd2,
        S_FINISH = 2'd3
    } state_e;

endpackage

// File: rtl/ax_shift_place.sv
module ax_shift_place
    import ax_shift_pkg::*;
#(
    parameter int W = 16
) (
    input  kind_e          kind,
    input  logic           left,
    input  logic [W-1:0]   din,
    input  logic           ov_in,
    output logic [W-1:0]   dout,
    output logic           ov_out
);

    // One place of movement for a W-bit word plus the link bit.
    always_comb begin
        dout   = din;
        ov_out = ov_in;
        case (kind)
            K_LOG: begin
                if (left) dout = {din[W-2:0], 1'b0};
                else      dout = {1'b0, din[W-1:1]};
            end
            K_ARI: begin
                if (left) begin
                    dout   = {din[W-2:0], 1'b0};
                    ov_out = ov_in | (din[W-1] ^ din[W-2]);
                end else begin
                    dout = {din[W-1], din[W-1:1]};
                end
            end
            K_ROT: begin
                if (left) {ov_out, dout} = {din, ov_in};
                else      {dout, ov_out} = {ov_in, din};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ax_shift_ctrl.sv
module ax_shift_ctrl
    import ax_shift_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_e         kind_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          norm_stop,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          step_en,
    output logic          norm_step
);

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    cnt_d = cnt_in;
                    if (kind_in == K_COPY)
                        state_d = S_FINISH;
                    else if (kind_in == K_NORM)
                        state_d = S_NORM;
                    else if (cnt_in == '0)
                        state_d = S_FINISH;
                    else
                        state_d = S_SHIFT;
                end
            end
            S_SHIFT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CW'(1)) state_d = S_FINISH;
            end
            S_NORM: begin
                if (norm_stop) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        load      = (state_q == S_IDLE) && start;
        step_en   = (state_q == S_SHIFT);
        norm_step = (state_q == S_NORM) && !norm_stop;
    end

endmodule

// File: rtl/ax_shifter.sv
module ax_shifter
    import ax_shift_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [2:0]               kind,
    input  logic                     left,
    input  logic [1:0]               sel,
    input  logic [CW-1:0]            count,
    input  logic [DW-1:0]            a_in,
    input  logic [DW-1:0]            x_in,
    input  logic                     ov_in,
    output logic [DW-1:0]            a_out,
    output logic [DW-1:0]            x_out,
    output logic                     ov_out,
    output logic [$clog2(DW)+1-1:0]  norm_places,
    output logic                     busy,
    output logic                     done
);

    localparam int NW = $clog2(DW) + 1;

    logic [DW-1:0] a_q, x_q;
    logic          ov_q;
    logic [NW-1:0] nplc_q;
    kind_e         kind_q;
    logic          left_q;
    logic [1:0]    sel_q;

    logic load, step_en, norm_step, norm_stop;
    logic copy_bit;

    assign norm_stop = (x_q == '0) || (x_q[DW-1] ^ x_q[DW-2]);

    ax_shift_ctrl #(.CW(CW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind_in   (kind_e'(kind)),
        .cnt_in    (count),
        .norm_stop (norm_stop),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .step_en   (step_en),
        .norm_step (norm_step)
    );

    // One place of datapath: index 0 single register, index 1 the pair
    logic [2*DW-1:0] wide_in  [2];
    logic [2*DW-1:0] wide_out [2];
    logic            ov_nx    [2];

    assign wide_in[0] = {{DW{1'b0}}, (sel_q[0] ? x_q : a_q)};
    assign wide_in[1] = {a_q, x_q};

    for (genvar g = 0; g < 2; g++) begin : g_place
        localparam int PW = (g + 1) * DW;
        logic [PW-1:0] pout;
        ax_shift_place #(.W(PW)) place_i (
            .kind   (kind_q),
            .left   (left_q),
            .din    (wide_in[g][PW-1:0]),
            .ov_in  (ov_q),
            .dout   (pout),
            .ov_out (ov_nx[g])
        );
        assign wide_out[g] = (2*DW)'(pout);
    end

    assign copy_bit = sel[0] ? (left ? x_in[DW-1] : x_in[0])
                             : (left ? a_in[DW-1] : a_in[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            x_q    <= '0;
            ov_q   <= 1'b0;
            nplc_q <= '0;
            kind_q <= K_LOG;
            left_q <= 1'b0;
            sel_q  <= 2'd0;
        end else if (load) begin
            a_q    <= a_in;
            x_q    <= x_in;
            ov_q   <= (kind_e'(kind) == K_COPY) ? copy_bit : ov_in;
            nplc_q <= '0;
            kind_q <= kind_e'(kind);
            left_q <= left;
            sel_q  <= sel;
        end else if (step_en) begin
            ov_q <= sel_q[1] ? ov_nx[1] : ov_nx[0];
            if (sel_q[1]) begin
                a_q <= wide_out[1][2*DW-1:DW];
                x_q <= wide_out[1][DW-1:0];
            end else if (sel_q[0]) begin
                x_q <= wide_out[0][DW-1:0];
            end else begin
                a_q <= wide_out[0][DW-1:0];
            end
        end else if (norm_step) begin
            x_q    <= {x_q[DW-2:0], 1'b0};
            nplc_q <= nplc_q + 1'b1;
        end
    end

    assign a_out       = a_q;
    assign x_out       = x_q;
    assign ov_out      = ov_q;
    assign norm_places = nplc_q;

endmodule

// File: rtl/ax_shifter_chk.sv
module ax_shifter_chk #(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    kind,
    input logic [1:0]    sel,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] x_out,
    input logic          ov_out,
    input logic          busy,
    input logic          done
);

    logic [2:0] kind_c;
    logic [1:0] sel_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_c <= 3'd0;
            sel_c  <= 2'd0;
        end else if (start && !busy) begin
            kind_c <= kind;
            sel_c  <= sel;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(a_out) && $stable(x_out) && $stable(ov_out)));

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    p_copy_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && kind == 3'd4) |=> done);

    p_norm_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_c == 3'd3 && x_out != '0) |-> (x_out[DW-1] != x_out[DW-2]));

    p_single_x_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sel_c == 2'd0 && kind_c <= 3'd2) |-> $stable(x_out));

endmodule

bind ax_shifter ax_shifter_chk #(.DW(DW), .CW(CW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .kind   (kind),
    .sel    (sel),
    .a_out  (a_out),
    .x_out  (x_out),
    .ov_out (ov_out),
    .busy   (busy),
    .done   (done)
);

// File: tb/ax_shifter_tb_top.sv
`timescale 1ns/1ps
module ax_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  kind = 3'd0;
    logic        left = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [4:0]  count = 5'd0;
    logic [15:0] a_in = 16'h0, x_in = 16'h0;
    logic        ov_in = 1'b0;
    logic [15:0] a_out, x_out;
    logic        ov_out;
    logic [4:0]  norm_places;
    logic        busy, done;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ax_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .left(left),
        .sel(sel), .count(count), .a_in(a_in), .x_in(x_in), .ov_in(ov_in),
        .a_out(a_out), .x_out(x_out), .ov_out(ov_out),
        .norm_places(norm_places), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  kind;
        logic        left;
        logic [1:0]  sel;
        logic [4:0]  cnt;
        logic [15:0] a;
        logic [15:0] x;
        logic        ov;
        logic [15:0] ea;
        logic [15:0] ex;
        logic        eov;
        logic [4:0]  enp;
        logic [5:0]  elat;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 3'd0,1'b1,2'd0,5'd4,  16'h1234,16'h5678,1'b0, 16'h2340,16'h5678,1'b0, 5'd0, 6'd5},  // R3
        '{4'd3, 3'd0,1'b0,2'd1,5'd3,  16'hAAAA,16'h8F00,1'b1, 16'hAAAA,16'h11E0,1'b1, 5'd0, 6'd4},  // R3
        '{4'd4, 3'd1,1'b0,2'd0,5'd4,  16'h8010,16'h0000,1'b0, 16'hF801,16'h0000,1'b0, 5'd0, 6'd5},  // R4
        '{4'd4, 3'd1,1'b1,2'd1,5'd1,  16'h0000,16'h4000,1'b0, 16'h0000,16'h8000,1'b1, 5'd0, 6'd2},  // R4
        '{4'd4, 3'd1,1'b1,2'd0,5'd2,  16'h1000,16'h0000,1'b0, 16'h4000,16'h0000,1'b0, 5'd0, 6'd3},  // R4
        '{4'd5, 3'd2,1'b1,2'd0,5'd1,  16'h8001,16'h0000,1'b0, 16'h0002,16'h0000,1'b1, 5'd0, 6'd2},  // R5
        '{4'd5, 3'd2,1'b0,2'd1,5'd17, 16'h0000,16'h1234,1'b1, 16'h0000,16'h1234,1'b1, 5'd0, 6'd18}, // R5
        '{4'd5, 3'd2,1'b0,2'd1,5'd1,  16'h0000,16'h0001,1'b0, 16'h0000,16'h0000,1'b1, 5'd0, 6'd2},  // R5
        '{4'd6, 3'd0,1'b1,2'd2,5'd8,  16'h12AB,16'hCD34,1'b0, 16'hABCD,16'h3400,1'b0, 5'd0, 6'd9},  // R6
        '{4'd6, 3'd0,1'b0,2'd3,5'd20, 16'h8000,16'h0001,1'b1, 16'h0000,16'h0800,1'b1, 5'd0, 6'd21}, // R6
        '{4'd6, 3'd1,1'b0,2'd2,5'd16, 16'h8000,16'h1234,1'b0, 16'hFFFF,16'h8000,1'b0, 5'd0, 6'd17}, // R6
        '{4'd6, 3'd1,1'b1,2'd2,5'd2,  16'h2000,16'h0000,1'b0, 16'h8000,16'h0000,1'b1, 5'd0, 6'd3},  // R6
        '{4'd6, 3'd2,1'b1,2'd2,5'd1,  16'h8000,16'h0001,1'b1, 16'h0000,16'h0003,1'b1, 5'd0, 6'd2},  // R6
        '{4'd6, 3'd2,1'b0,2'd2,5'd1,  16'h0001,16'h0001,1'b0, 16'h0000,16'h8000,1'b1, 5'd0, 6'd2},  // R6
        '{4'd7, 3'd4,1'b1,2'd0,5'd9,  16'h8000,16'h0000,1'b0, 16'h8000,16'h0000,1'b1, 5'd0, 6'd1},  // R7
        '{4'd7, 3'd4,1'b0,2'd1,5'd0,  16'h0000,16'h0002,1'b1, 16'h0000,16'h0002,1'b0, 5'd0, 6'd1},  // R7
        '{4'd7, 3'd4,1'b1,2'd1,5'd0,  16'h0000,16'h7FFF,1'b1, 16'h0000,16'h7FFF,1'b0, 5'd0, 6'd1},  // R7
        '{4'd7, 3'd4,1'b0,2'd0,5'd0,  16'h0001,16'h0000,1'b0, 16'h0001,16'h0000,1'b1, 5'd0, 6'd1},  // R7
        '{4'd8, 3'd3,1'b0,2'd1,5'd0,  16'h5555,16'h0001,1'b0, 16'h5555,16'h4000,1'b0, 5'd14,6'd16}, // R8
        '{4'd8, 3'd3,1'b0,2'd1,5'd0,  16'h0000,16'h0000,1'b1, 16'h0000,16'h0000,1'b1, 5'd0, 6'd2},  // R8
        '{4'd8, 3'd3,1'b0,2'd1,5'd0,  16'h0000,16'hFFFF,1'b0, 16'h0000,16'h8000,1'b0, 5'd15,6'd17}, // R8
        '{4'd8, 3'd3,1'b0,2'd1,5'd0,  16'h0000,16'h4000,1'b0, 16'h0000,16'h4000,1'b0, 5'd0, 6'd2},  // R8
        '{4'd2, 3'd0,1'b1,2'd0,5'd0,  16'h1234,16'h5678,1'b1, 16'h1234,16'h5678,1'b1, 5'd0, 6'd1},  // R2
        '{4'd5, 3'd2,1'b1,2'd0,5'd16, 16'h1234,16'h0000,1'b0, 16'h091A,16'h0000,1'b0, 5'd0, 6'd17}  // R5
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Pulse start at a falling edge, count rising edges until done is seen.
    task automatic issue(input logic [2:0] k, input logic l, input logic [1:0] s,
                         input logic [4:0] c, input logic [15:0] a,
                         input logic [15:0] x, input logic o, output int lat);
        kind = k; left = l; sel = s; count = c; a_in = a; x_in = x; ov_in = o;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "a_out", 32'(a_out), 32'h0);
        check("R1", "x_out", 32'(x_out), 32'h0);
        check("R1", "ov/busy/done/np", {25'd0, ov_out, busy, done, norm_places}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].kind, VEC[i].left, VEC[i].sel, VEC[i].cnt,
                  VEC[i].a, VEC[i].x, VEC[i].ov, lat);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d a", i), 32'(a_out), 32'(VEC[i].ea));
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d x", i), 32'(x_out), 32'(VEC[i].ex));
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d ov", i), 32'(ov_out), 32'(VEC[i].eov));
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d places", i), 32'(norm_places), 32'(VEC[i].enp));
            // R2 latency from start edge
            check("R2", $sformatf("vec %0d latency", i), 32'(lat), 32'(VEC[i].elat));
            @(negedge clk);
        end

        // R9: start while busy is ignored
        kind = 3'd0; left = 1'b1; sel = 2'd0; count = 5'd6;
        a_in = 16'h0001; x_in = 16'h0F0F; ov_in = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy after start", 32'(busy), 32'h1);
        @(negedge clk);
        kind = 3'd4; left = 1'b1; sel = 2'd0; a_in = 16'hFFFF; ov_in = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy mid shift", 32'(busy), 32'h1);
        lat = 3;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check("R9", "latency", 32'(lat), 32'd7);
        check("R9", "a result", 32'(a_out), 32'h0040);
        check("R9", "x result", 32'(x_out), 32'h0F0F);
        check("R9", "ov result", 32'(ov_out), 32'h0);

        // R10: done one cycle, outputs hold while idle with changing inputs
        @(negedge clk);
        check("R10", "done drop", 32'(done), 32'h0);
        check("R9", "busy drop", 32'(busy), 32'h0);
        a_in = 16'hDEAD; x_in = 16'hBEEF; ov_in = 1'b1; kind = 3'd2;
        repeat (4) @(negedge clk);
        check("R10", "hold a", 32'(a_out), 32'h0040);
        check("R10", "hold x", 32'(x_out), 32'h0F0F);
        check("R10", "hold ov/done", {30'd0, ov_out, done}, 32'h0);

        // R1 reset again mid operation
        issue(3'd0, 1'b1, 2'd2, 5'd0, 16'h1111, 16'h2222, 1'b1, lat);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "reset clears a/x", {a_out, x_out}, 32'h0);
        check("R1", "reset clears ov/busy/done", {29'd0, ov_out, busy, done}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule